// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing half of a byte-addressed serial EEPROM. It runs on a fast system clock and takes the raw clock and data lines of a two-wire serial bus. It synchronises and deglitches both lines and recognises START and STOP conditions. It then works through the transaction. First comes a device-select byte, which is a fixed type code, three strap bits and a direction bit. A write then carries two word-address bytes and data bytes. A read streams bytes out for as long as the master keeps acknowledging. The data line is driven only through an open-drain enable: when the enable is high the line is pulled low.

Storage sits outside the block and is reached through a simple byte port. The port carries one address, one write-data byte with a single-cycle write strobe, and a read-data byte. The read-data byte must reflect the address by the next SCL falling edge. The storage write controller reports through a busy input that it is still committing earlier data. While that input is high the engine refuses its own device select, so a master can poll for completion. One internal pointer serves reads and writes. Writes advance it within a page. Reads advance it across the whole array. A current-address read therefore continues from wherever the last access stopped, and a random read loads the pointer with a write that carries no data.

Top module: `ee2w_slave`

## Requirements
- R1: After reset the open-drain enable `sda_oe` is low and `mem_we` is low.
- R2: A device-select byte is accepted only when its bits [7:4] equal 1010 and bits [3:1] equal `dev_sel`. Bit 0 selects the direction (1 read, 0 write). The engine accepts by pulling SDA low for the ninth clock. On a mismatch it leaves SDA released and ignores every further byte until the next START.
- R3: After an accepted write select, the next two bytes form the word address, high byte first. Every later byte is acknowledged and presented once on `mem_wdata`/`mem_addr` with a one-clock `mem_we` pulse.
- R4: After each written byte only the low `PAGE_W` bits of the pointer advance. They wrap from all-ones to zero inside the same page.
- R5: A read select that is not preceded by word-address bytes returns the byte at the pointer left by the previous access.
- R6: A write select followed by two word-address bytes, then a repeated START and a read select, returns the byte at the address just loaded.
- R7: During a read, a master acknowledge (SDA low on the ninth clock) causes the next byte to be sent. The pointer advances across the whole array and wraps from the top address to zero. A master non-acknowledge ends the read with SDA released.
- R8: While `wr_busy` is high when the device-select byte completes, that byte is not acknowledged.
- R9: A START seen part-way through a byte abandons that byte and restarts device-select reception.
- R10: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks has no effect on the transaction.
- R11: Word-address bits at and above `ADDR_W` are ignored.
- R12: `sda_oe` changes only while SCL is low, except for the release at a START or STOP.
- R13: A STOP ends any transaction. Bytes sent after it without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, as seen on the wire |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| dev_sel | input | 3 | Strap bits compared with select bits [3:1] |
| wr_busy | input | 1 | Storage write controller still committing |
| mem_addr | output | ADDR_W | Byte address for the storage port |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-clock write strobe |
| mem_rdata | input | 8 | Byte read at `mem_addr` |

## Verification
Each filtered line lags its pin by two synchroniser stages, `FILT_LEN` filter clocks and one edge register, which is about six clocks with the default settings. A drive change on `sda_oe` appears one clock after the filtered SCL fall that causes it. A write strobe follows one clock after the fall that closes the eighth data bit. The bench moves SCL in quarter periods of sixteen clocks and samples SDA one quarter into each high phase, well after every one of those delays has settled. Stored contents are never read directly; they are checked by reading them back over the bus against a reference array that bench functions keep. Glitches are injected two clocks wide, one clock short of the filter length.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } ee2w_state_e;

   typedef enum logic [1:0] {
      K_DEV,
      K_AHI,
      K_ALO,
      K_DATA
   } ee2w_kind_e;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
   localparam int         BYTE_W   = 8;

endpackage

// File: rtl/ee2w_deglitch.sv
module ee2w_deglitch #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   logic [1:0] sync_q;
   logic       out_q;

   generate
      if (FILT_LEN < 1) begin : g_bad_len
         $error("ee2w_deglitch: FILT_LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], din};
   end

   generate
      if (FILT_LEN < 2) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b1;
            else        out_q <= sync_q[1];
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else if (sync_q[1] != out_q) begin
               if (cnt_q == CW'(FILT_LEN - 1)) begin
                  out_q <= sync_q[1];
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end
      end
   endgenerate

   assign dout = out_q;

   // R10: the filtered level only ever moves to the synchronised input level
   assert_flip_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |-> ($past(sync_q[1]) == out_q));

endmodule

// File: rtl/ee2w_busev.sv
module ee2w_busev (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  =  scl & ~scl_q;
   assign scl_fall  = ~scl &  scl_q;
   assign bus_start =  scl &  scl_q &  sda_q & ~sda;
   assign bus_stop  =  scl &  scl_q & ~sda_q &  sda;

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
   import ee2w_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int PAGE_W   = 5,
   parameter int FILT_LEN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        dev_sel,
   input  logic              wr_busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata
);
   localparam int WORD_ADDR_W = 2 * BYTE_W;
   localparam int NLINES      = 2;

   generate
      if (ADDR_W > WORD_ADDR_W || ADDR_W <= PAGE_W) begin : g_bad_addr
         $error("ee2w_slave: need PAGE_W < ADDR_W <= 16");
      end
   endgenerate

   // line 0 = SCL, line 1 = SDA
   logic [NLINES-1:0] raw_l, flt_l;
   assign raw_l = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         ee2w_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_l[g]),
            .dout (flt_l[g])
         );
      end
   endgenerate

   logic scl_f, sda_f;
   assign scl_f = flt_l[0];
   assign sda_f = flt_l[1];

   logic ev_rise, ev_fall, ev_start, ev_stop;

   ee2w_busev u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_f),
      .sda      (sda_f),
      .scl_rise (ev_rise),
      .scl_fall (ev_fall),
      .bus_start(ev_start),
      .bus_stop (ev_stop)
   );

   ee2w_state_e       state_q;
   ee2w_kind_e        kind_q;
   logic [3:0]        cnt_q;
   logic [7:0]        shr_q;
   logic [7:0]        hi_q;
   logic [7:0]        wdat_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              rw_q, oe_q, we_q, mack_q;

   function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] r;
      r = a;
      r[PAGE_W-1:0] = a[PAGE_W-1:0] + 1'b1;
      return r;
   endfunction

   logic dev_hit;
   assign dev_hit = (shr_q[7:4] == DEV_TYPE) && (shr_q[3:1] == dev_sel) && !wr_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= K_DEV;
         cnt_q   <= '0;
         shr_q   <= '0;
         hi_q    <= '0;
         wdat_q  <= '0;
         ptr_q   <= '0;
         rw_q    <= 1'b0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
         mack_q  <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (ev_start) begin
            state_q <= ST_RX;
            kind_q  <= K_DEV;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else if (ev_stop) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_RX: begin
                  if (ev_rise && cnt_q < 4'd8) begin
                     shr_q <= {shr_q[6:0], sda_f};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (ev_fall && cnt_q == 4'd8) begin
                     case (kind_q)
                        K_DEV: begin
                           if (dev_hit) begin
                              rw_q    <= shr_q[0];
                              oe_q    <= 1'b1;
                              state_q <= ST_ACK;
                           end else begin
                              state_q <= ST_IDLE;
                           end
                        end
                        K_AHI: begin
                           hi_q    <= shr_q;
                           oe_q    <= 1'b1;
                           state_q <= ST_ACK;
                        end
                        K_ALO: begin
                           ptr_q   <= ADDR_W'({hi_q, shr_q});
                           oe_q    <= 1'b1;
                           state_q <= ST_ACK;
                        end
                        default: begin
                           we_q    <= 1'b1;
                           wdat_q  <= shr_q;
                           oe_q    <= 1'b1;
                           state_q <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (ev_fall) begin
                     oe_q  <= 1'b0;
                     cnt_q <= '0;
                     case (kind_q)
                        K_DEV: begin
                           if (rw_q) begin
                              state_q <= ST_TX;
                              shr_q   <= mem_rdata;
                              oe_q    <= ~mem_rdata[7];
                           end else begin
                              kind_q  <= K_AHI;
                              state_q <= ST_RX;
                           end
                        end
                        K_AHI: begin
                           kind_q  <= K_ALO;
                           state_q <= ST_RX;
                        end
                        K_ALO: begin
                           kind_q  <= K_DATA;
                           state_q <= ST_RX;
                        end
                        default: begin
                           ptr_q   <= page_inc(ptr_q);
                           state_q <= ST_RX;
                        end
                     endcase
                  end
               end
               ST_TX: begin
                  if (ev_rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (ev_fall) begin
                     if (cnt_q == 4'd8) begin
                        oe_q    <= 1'b0;
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= ST_MACK;
                     end else begin
                        shr_q <= {shr_q[6:0], 1'b0};
                        oe_q  <= ~shr_q[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (ev_rise) begin
                     mack_q <= ~sda_f;
                  end else if (ev_fall) begin
                     if (mack_q) begin
                        shr_q   <= mem_rdata;
                        oe_q    <= ~mem_rdata[7];
                        cnt_q   <= '0;
                        state_q <= ST_TX;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = oe_q;
   assign mem_addr  = ptr_q;
   assign mem_wdata = wdat_q;
   assign mem_we    = we_q;

   // R12: drive changes happen in the SCL low phase unless a START/STOP released the line
   assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(oe_q) && !$past(ev_start) && !$past(ev_stop)) |-> !scl_f);

   // R8: an acknowledged device select never coincides with a busy storage controller
   assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK && kind_q == K_DEV && $past(state_q) == ST_RX) |-> !$past(wr_busy));

   // R3: the store strobe lasts a single clock
   assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R4: pointer moves after a stored byte keep the page bits
   assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_ACK && $past(kind_q) == K_DATA && state_q == ST_RX)
         |-> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

   // R13: a STOP leaves the line released and the engine idle
   assert_stop_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (!sda_oe && state_q == ST_IDLE));

   // R7: the master acknowledge slot is never driven by the engine
   assert_mack_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MACK) |-> !sda_oe);

endmodule

// File: tb/ee2w_slave_test.sv
module ee2w_slave_test;
   localparam int AW   = 10;
   localparam int PW   = 5;
   localparam int FL   = 3;
   localparam int Q    = 16;
   localparam int MEMN = 1 << AW;
   localparam int PSZ  = 1 << PW;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       scl_drv = 1'b1;
   logic       sda_drv = 1'b1;
   logic [2:0] sel     = 3'b101;
   logic       busy    = 1'b0;
   logic       glitch  = 1'b0;
   logic       sda_oe, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic       sda_line;
   assign sda_line = sda_drv & ~sda_oe;

   logic [7:0] store   [MEMN];
   logic [7:0] ref_mem [MEMN];
   logic [7:0] dbuf    [64];
   int ref_ptr = 0;
   int nchk = 0, nfail = 0, r12_bad = 0;
   logic oe_prev = 1'b0;

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 37 + 11);
   endfunction

   function automatic int page_next(input int a);
      return (a & ~(PSZ - 1)) | ((a + 1) & (PSZ - 1));
   endfunction

   function automatic int lin_next(input int a);
      return (a + 1) % MEMN;
   endfunction

   assign mem_rdata = store[mem_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEMN; i++) store[i] <= pat(i);
      end else if (mem_we) begin
         store[mem_addr] <= mem_wdata;
      end
   end

   ee2w_slave #(.ADDR_W(AW), .PAGE_W(PW), .FILT_LEN(FL)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_drv),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .dev_sel  (sel),
      .wr_busy  (busy),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_we   (mem_we),
      .mem_rdata(mem_rdata)
   );

   // R12 monitor: the drive enable must hold still while SCL is high
   always @(negedge clk) begin
      if (rst_n && (sda_oe != oe_prev) && scl_drv) r12_bad++;
      oe_prev = sda_oe;
   end

   task automatic qw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic start_c();
      sda_drv = 1'b1; qw(Q);
      scl_drv = 1'b1; qw(Q);
      sda_drv = 1'b0; qw(Q);
      scl_drv = 1'b0; qw(Q);
   endtask

   task automatic stop_c();
      sda_drv = 1'b0; qw(Q);
      scl_drv = 1'b1; qw(Q);
      sda_drv = 1'b1; qw(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_drv = b;
      qw(Q / 2);
      if (glitch) begin
         scl_drv = 1'b1; qw(FL - 1); scl_drv = 1'b0;
         qw(Q / 2 - (FL - 1));
      end else begin
         qw(Q / 2);
      end
      scl_drv = 1'b1;
      qw(Q);
      if (glitch) begin
         sda_drv = !b; qw(FL - 1); sda_drv = b;
         qw(Q - (FL - 1));
      end else begin
         qw(Q);
      end
      scl_drv = 1'b0;
      qw(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_drv = 1'b1; qw(Q);
      scl_drv = 1'b1; qw(Q);
      b = sda_line;   qw(Q);
      scl_drv = 1'b0; qw(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic get_byte(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!mack);
   endtask

   task automatic dev_byte(input logic rw, output logic ack);
      put_byte({4'b1010, sel, rw}, ack);
   endtask

   task automatic wr_txn(input int addr, input int n, input bit gl, input string tag);
      logic a;
      start_c();
      dev_byte(1'b0, a);        chk(a, tag, a, 1);
      put_byte(8'(addr >> 8), a); chk(a, tag, a, 1);
      put_byte(8'(addr), a);      chk(a, tag, a, 1);
      ref_ptr = addr & (MEMN - 1);
      glitch = gl;
      for (int i = 0; i < n; i++) begin
         put_byte(dbuf[i], a);
         chk(a, tag, a, 1);
         ref_mem[ref_ptr] = dbuf[i];
         ref_ptr = page_next(ref_ptr);
      end
      glitch = 1'b0;
      stop_c();
   endtask

   task automatic rd_seq(input bit rnd, input int addr, input int n, input string tag);
      logic a;
      logic [7:0] v;
      if (rnd) begin
         start_c();
         dev_byte(1'b0, a);          chk(a, tag, a, 1);
         put_byte(8'(addr >> 8), a); chk(a, tag, a, 1);
         put_byte(8'(addr), a);      chk(a, tag, a, 1);
         ref_ptr = addr & (MEMN - 1);
      end
      start_c();
      dev_byte(1'b1, a);
      chk(a, tag, a, 1);
      for (int i = 0; i < n; i++) begin
         get_byte(i < n - 1, v);
         chk(v == ref_mem[ref_ptr], tag, v, ref_mem[ref_ptr]);
         ref_ptr = lin_next(ref_ptr);
      end
      stop_c();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : main
      logic a;
      logic [7:0] v;
      int addr, n;
      for (int i = 0; i < MEMN; i++) ref_mem[i] = pat(i);
      void'($urandom(32'd4321));

      // R1: reset state
      qw(5);
      chk(sda_oe == 1'b0, "R1", sda_oe, 0);
      chk(mem_we == 1'b0, "R1", mem_we, 0);
      rst_n = 1'b1;
      qw(20);
      chk(sda_oe == 1'b0, "R1", sda_oe, 0);

      // R2: wrong strap and wrong type code are refused, later bytes ignored
      start_c();
      put_byte({4'b1010, ~sel, 1'b0}, a); chk(!a, "R2", a, 0);
      put_byte(8'h00, a);                 chk(!a, "R2", a, 0);
      stop_c();
      start_c();
      put_byte({4'b1011, sel, 1'b0}, a);  chk(!a, "R2", a, 0);
      stop_c();

      // R3 then R5: byte write, current read continues after it
      dbuf[0] = 8'hA5; dbuf[1] = 8'h3C;
      wr_txn(300, 2, 1'b0, "R3");
      rd_seq(1'b0, 0, 1, "R5");
      // R6: random read of the written bytes
      rd_seq(1'b1, 300, 2, "R6");

      // R4: 34 bytes from page offset 30 wrap inside the page
      for (int i = 0; i < 34; i++) dbuf[i] = 8'(200 + i);
      wr_txn(5 * PSZ + 30, 34, 1'b0, "R4");
      rd_seq(1'b1, 5 * PSZ, PSZ, "R4");

      // R7: sequential read across the top of the array
      rd_seq(1'b1, MEMN - 2, 4, "R7");

      // R8: busy storage refuses selection, then accepts
      busy = 1'b1;
      start_c(); dev_byte(1'b0, a); chk(!a, "R8", a, 0); stop_c();
      busy = 1'b0;
      start_c(); dev_byte(1'b0, a); chk(a, "R8", a, 1); stop_c();

      // R9: START in mid byte restarts select reception
      start_c();
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      start_c();
      dev_byte(1'b1, a); chk(a, "R9", a, 1);
      get_byte(1'b0, v);
      chk(v == ref_mem[ref_ptr], "R9", v, ref_mem[ref_ptr]);
      ref_ptr = lin_next(ref_ptr);
      stop_c();

      // R10: short pulses on both lines during data bytes
      dbuf[0] = 8'h81; dbuf[1] = 8'h7E; dbuf[2] = 8'h55;
      wr_txn(600, 3, 1'b1, "R10");
      rd_seq(1'b1, 600, 3, "R10");

      // R11: upper word-address bits dropped
      dbuf[0] = 8'hC3;
      wr_txn(16'hFC05, 1, 1'b0, "R11");
      rd_seq(1'b1, 5, 1, "R11");

      // R13: STOP after the high address byte; further bytes are refused
      start_c();
      dev_byte(1'b0, a);   chk(a, "R13", a, 1);
      put_byte(8'h01, a);  chk(a, "R13", a, 1);
      stop_c();
      scl_drv = 1'b0; qw(Q);
      put_byte(8'h55, a);  chk(!a, "R13", a, 0);
      stop_c();

      // constrained random page writes and read-backs (R3/R11 and R6)
      for (int t = 0; t < 5; t++) begin
         addr = int'($urandom % 65536);
         n    = 1 + int'($urandom % 6);
         for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
         wr_txn(addr, n, 1'b0, "R3/R11");
         rd_seq(1'b1, addr & ~(PSZ - 1), PSZ / 4, "R6");
      end

      chk(r12_bad == 0, "R12", r12_bad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule